// File: doc/BRIEF.md
# BCH Error Location Corrector

This block takes the result of a BCH decode for a page of up to eight sectors and applies it to a sector buffer. For each sector it reads a 4-bit error count from a packed count word. It waits for that sector's decode-complete flag. It then walks the reported bit locations and flips each addressed bit in the buffer with a read, an XOR and a write. Each sector's buffer has two regions: a 512-byte payload region and an 8-byte metadata region. A location is steered to one of them by comparing it against the region boundaries. Locations that point into the parity area touch nothing.

A controller starts a page with a single pulse. The pulse carries the index of the last sector and the correction strength code. The block reports which sector it is working on, so that the location words of that sector can be presented. At the end it raises a one-cycle done pulse. The results are a sticky fail flag for any uncorrectable sector and the largest correctable error count seen in the page.

Top module: `bch_loc_fix`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, buf_re_o and buf_we_o are 0 and max_cnt_o is 0.
- R2: Sectors are handled in order from 0 to last_sect_i. Sector n's count is cnt_word_i[4n+3:4n]. The block does not start work on sector n, including any buffer access, until dec_done_i[n] is 1. While it waits, sect_o shows n.
- R3: A count of 0 causes no buffer access for that sector.
- R4: A count that is all ones, or above the strength limit, marks the sector uncorrectable and flips nothing. The strength limit is 4+2*code for strength_i codes 0..3, and 12 for codes 4..7. fail_o then stays 1 until the next start.
- R5: Location i of the current sector is held in word i/2 of loc_words_i, where word j is loc_words_i[32j+31:32j]. Even i uses bits [12:0] of the word and odd i uses bits [28:16]. All other bits are ignored.
- R6: A location L below 4096 flips bit L[2:0] of payload byte L>>3 (buf_meta_o=0).
- R7: A location L from 4096 to 4159 flips bit L[2:0] of metadata byte (L>>3)-512 (buf_meta_o=1).
- R8: A location of 4160 or more causes no buffer access, but it still counts toward the sector's corrected count.
- R9: Each location takes exactly two cycles. In the first cycle the byte is read (buf_re_o). In the next cycle the same address is written (buf_we_o) with the read data XOR a one-hot bit mask. Read data arrives one cycle after buf_re_o. Two locations on the same bit cancel.
- R10: When the page is complete, done_o is 1 for exactly one cycle. At that point max_cnt_o holds the maximum count over the page's correctable sectors, and fail_o and max_cnt_o are cleared by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a page (taken when idle) |
| last_sect_i | input | 3 | Index of the last sector of the page |
| strength_i | input | 3 | Correction strength code |
| cnt_word_i | input | 32 | Packed 4-bit error counts, one per sector |
| dec_done_i | input | 8 | Per-sector decode-complete flags |
| loc_words_i | input | 192 | Location words of the sector shown on sect_o |
| sect_o | output | 3 | Sector currently handled |
| buf_re_o | output | 1 | Buffer read strobe |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_meta_o | output | 1 | 1 selects the metadata region |
| buf_addr_o | output | 10 | Byte offset within the selected region |
| buf_wdata_o | output | 8 | Write data (read data with one bit flipped) |
| buf_rdata_i | input | 8 | Read data, valid one cycle after buf_re_o |
| busy_o | output | 1 | A page is in progress |
| done_o | output | 1 | One-cycle page completion pulse |
| fail_o | output | 1 | Sticky uncorrectable flag for the page |
| max_cnt_o | output | 4 | Largest correctable count in the page |

## Verification
A wrong location index or a wrong halfword select shows up in the buffer contents at the done pulse, because the bits flipped will not be the ones asked for. A wrong phase bit in the read-modify-write unit shows up within one cycle: a write appears without a read in the cycle before it, or to a different address. A bad sector counter or flag test shows as buffer traffic while a decode flag is still low. A bad limit compare or a bad max compare shows directly on fail_o and max_cnt_o at the done pulse.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_META = 2'd1,
    RGN_SKIP = 2'd2
  } rgn_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FIX,
    ST_DONE
  } fix_st_e;

  // correctable bits per sector for a strength code
  function automatic logic [3:0] strength_limit(input logic [2:0] code);
    if (code >= 3'd4) return 4'd12;
    else return 4'd4 + {1'b0, code[1:0], 1'b0};
  endfunction

endpackage

// File: rtl/bch_loc_decode.sv
module bch_loc_decode
  import bch_fix_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int META_BYTES = 8,
  parameter int LOC_W      = 13,
  parameter int MAX_ERR    = 12,
  localparam int NUM_WORDS = MAX_ERR / 2,
  localparam int IDX_W     = $clog2(MAX_ERR),
  localparam int BYTE_W    = LOC_W - 3
) (
  input  logic [NUM_WORDS*32-1:0] loc_words_i,
  input  logic [IDX_W-1:0]        idx_i,
  output rgn_e                    rgn_o,
  output logic [BYTE_W-1:0]       byte_o,
  output logic [7:0]              mask_o
);

  localparam logic [LOC_W-1:0]  DATA_END  = LOC_W'(SECT_BYTES * 8);
  localparam logic [LOC_W-1:0]  META_END  = LOC_W'((SECT_BYTES + META_BYTES) * 8);
  localparam logic [BYTE_W-1:0] META_BASE = BYTE_W'(SECT_BYTES);

  logic [LOC_W-1:0]     locs [MAX_ERR];
  logic [NUM_WORDS-1:0] unused_pad;

  generate
    for (genvar g = 0; g < MAX_ERR; g++) begin : g_loc
      // even locations in the low half, odd in the high half
      assign locs[g] = loc_words_i[32*(g/2) + 16*(g%2) +: LOC_W];
    end
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pad
      assign unused_pad[w] = ^{loc_words_i[32*w + 16 + LOC_W +: 16 - LOC_W],
                               loc_words_i[32*w + LOC_W +: 16 - LOC_W]};
    end
  endgenerate

  logic [LOC_W-1:0]  loc;
  logic [BYTE_W-1:0] byte_full;

  always_comb begin
    loc       = (idx_i < IDX_W'(MAX_ERR)) ? locs[idx_i] : '1;
    byte_full = loc[LOC_W-1:3];
    mask_o    = 8'(1) << loc[2:0];
    if (loc < DATA_END) begin
      rgn_o  = RGN_DATA;
      byte_o = byte_full;
    end else if (loc < META_END) begin
      rgn_o  = RGN_META;
      byte_o = byte_full - META_BASE;
    end else begin
      rgn_o  = RGN_SKIP;
      byte_o = '0;
    end
  end

endmodule

// File: rtl/bch_loc_rmw.sv
module bch_loc_rmw
  import bch_fix_pkg::*;
#(
  parameter int BYTE_W     = 10,
  parameter int META_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  rgn_e              rgn_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [7:0]        mask_i,
  input  logic [7:0]        buf_rdata_i,
  output logic              buf_re_o,
  output logic              buf_we_o,
  output logic              buf_meta_o,
  output logic [BYTE_W-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  output logic              loc_done_o
);

  logic              ph_q, act_q, meta_q;
  logic [BYTE_W-1:0] addr_q;
  logic [7:0]        mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      act_q  <= 1'b0;
      meta_q <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
    end else if (step_i) begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        act_q  <= (rgn_i != RGN_SKIP);
        meta_q <= (rgn_i == RGN_META);
        addr_q <= byte_i;
        mask_q <= mask_i;
      end
    end else begin
      ph_q <= 1'b0;
    end
  end

  always_comb begin
    buf_re_o    = step_i & ~ph_q & (rgn_i != RGN_SKIP);
    buf_we_o    = step_i & ph_q & act_q;
    buf_meta_o  = ph_q ? meta_q : (rgn_i == RGN_META);
    buf_addr_o  = ph_q ? addr_q : byte_i;
    buf_wdata_o = buf_rdata_i ^ mask_q;
    loc_done_o  = step_i & ph_q;
  end

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> $past(buf_re_o) && $stable(buf_addr_o) && $stable(buf_meta_o)); // R9
  AST_NO_RW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_re_o && buf_we_o)); // R9
  AST_META_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_re_o && buf_meta_o |-> buf_addr_o < BYTE_W'(META_BYTES)); // R7
  AST_SKIP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !ph_q && rgn_i == RGN_SKIP |=> !buf_we_o); // R8

endmodule

// File: rtl/bch_loc_fix.sv
module bch_loc_fix
  import bch_fix_pkg::*;
#(
  parameter int MAX_SECT   = 8,
  parameter int CNT_W      = 4,
  parameter int SECT_BYTES = 512,
  parameter int META_BYTES = 8,
  parameter int LOC_W      = 13,
  parameter int MAX_ERR    = 12,
  localparam int SECT_W    = $clog2(MAX_SECT),
  localparam int NUM_WORDS = MAX_ERR / 2,
  localparam int IDX_W     = $clog2(MAX_ERR),
  localparam int BYTE_W    = LOC_W - 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [SECT_W-1:0]         last_sect_i,
  input  logic [2:0]                strength_i,
  input  logic [MAX_SECT*CNT_W-1:0] cnt_word_i,
  input  logic [MAX_SECT-1:0]       dec_done_i,
  input  logic [NUM_WORDS*32-1:0]   loc_words_i,
  output logic [SECT_W-1:0]         sect_o,
  output logic                      buf_re_o,
  output logic                      buf_we_o,
  output logic                      buf_meta_o,
  output logic [BYTE_W-1:0]         buf_addr_o,
  output logic [7:0]                buf_wdata_o,
  input  logic [7:0]                buf_rdata_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      fail_o,
  output logic [CNT_W-1:0]          max_cnt_o
);

  fix_st_e           st_q;
  logic [SECT_W-1:0] sect_q, last_q;
  logic [CNT_W-1:0]  lim_q, cnt_q, max_q;
  logic [IDX_W-1:0]  idx_q;
  logic              fail_q;

  logic [CNT_W-1:0]  cur_cnt;
  logic              flag, at_last, idx_last, loc_done;
  rgn_e              rgn;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        mask;

  assign cur_cnt  = cnt_word_i[sect_q*CNT_W +: CNT_W];
  assign flag     = dec_done_i[sect_q];
  assign at_last  = (sect_q == last_q);
  assign idx_last = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sect_q <= '0;
      last_q <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      max_q  <= '0;
      idx_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sect_q <= '0;
          last_q <= last_sect_i;
          lim_q  <= CNT_W'(strength_limit(strength_i));
          max_q  <= '0;
          fail_q <= 1'b0;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: if (flag) begin
          if (cur_cnt == '1 || cur_cnt > lim_q || cur_cnt == '0) begin
            if (cur_cnt != '0) fail_q <= 1'b1;
            if (at_last) st_q <= ST_DONE;
            else sect_q <= sect_q + SECT_W'(1);
          end else begin
            cnt_q <= cur_cnt;
            idx_q <= '0;
            if (cur_cnt > max_q) max_q <= cur_cnt;
            st_q  <= ST_FIX;
          end
        end
        ST_FIX: if (loc_done) begin
          if (idx_last) begin
            if (at_last) st_q <= ST_DONE;
            else begin
              sect_q <= sect_q + SECT_W'(1);
              st_q   <= ST_WAIT;
            end
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  bch_loc_decode #(
    .SECT_BYTES(SECT_BYTES), .META_BYTES(META_BYTES),
    .LOC_W(LOC_W), .MAX_ERR(MAX_ERR)
  ) u_decode (
    .loc_words_i(loc_words_i),
    .idx_i      (idx_q),
    .rgn_o      (rgn),
    .byte_o     (byte_idx),
    .mask_o     (mask)
  );

  bch_loc_rmw #(.BYTE_W(BYTE_W), .META_BYTES(META_BYTES)) u_rmw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (st_q == ST_FIX),
    .rgn_i      (rgn),
    .byte_i     (byte_idx),
    .mask_i     (mask),
    .buf_rdata_i(buf_rdata_i),
    .buf_re_o   (buf_re_o),
    .buf_we_o   (buf_we_o),
    .buf_meta_o (buf_meta_o),
    .buf_addr_o (buf_addr_o),
    .buf_wdata_o(buf_wdata_o),
    .loc_done_o (loc_done)
  );

  assign sect_o    = sect_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_DONE);
  assign fail_o    = fail_q;
  assign max_cnt_o = max_q;

  AST_WAIT_FOR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_re_o |-> dec_done_i[sect_o]); // R2
  AST_ZERO_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT && flag && cur_cnt == '0 |=> !buf_re_o); // R3
  AST_BAD_SETS_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT && flag && (cur_cnt == '1 || cur_cnt > lim_q) |=> fail_o && !buf_re_o); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !(start_i && !busy_o) |=> fail_o); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_MAX_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> max_cnt_o >= $past(max_cnt_o)); // R10

endmodule

// File: tb/tb_bch_loc_fix.sv
`timescale 1ns/1ps
module tb_bch_loc_fix;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   last_sect = '0, strength = '0;
  logic [31:0]  cnt_word = '0;
  logic [7:0]   dec_done = '0;
  logic [191:0] lw;
  logic [2:0]   sect;
  logic         re, we, meta, busy, done, fail;
  logic [9:0]   addr;
  logic [7:0]   wdata, rdata;
  logic [3:0]   max_cnt;

  always #2.5 clk = ~clk;

  bch_loc_fix dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_sect_i(last_sect),
    .strength_i(strength), .cnt_word_i(cnt_word), .dec_done_i(dec_done),
    .loc_words_i(lw), .sect_o(sect), .buf_re_o(re), .buf_we_o(we),
    .buf_meta_o(meta), .buf_addr_o(addr), .buf_wdata_o(wdata),
    .buf_rdata_i(rdata), .busy_o(busy), .done_o(done), .fail_o(fail),
    .max_cnt_o(max_cnt)
  );

  logic [7:0]  mem_d [512];
  logic [7:0]  mem_m [8];
  logic [7:0]  exp_d [512];
  logic [7:0]  exp_m [8];
  logic [12:0] locs [8][12];

  always_comb begin
    lw = '0;
    for (int j = 0; j < 6; j++)
      lw[32*j +: 32] = {3'b111, locs[sect][2*j+1], 3'b111, locs[sect][2*j]};
  end

  always @(posedge clk) begin
    if (re) rdata <= meta ? mem_m[addr[2:0]] : mem_d[addr[8:0]];
    if (we) begin
      if (meta) mem_m[addr[2:0]] <= wdata;
      else mem_d[addr[8:0]] <= wdata;
    end
  end

  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0, seq_bad = 0;
  bit fin = 1'b0, prev_re = 1'b0, prev_meta = 1'b0;
  logic [9:0] prev_addr = '0;

  always @(negedge clk) begin
    if (re) rd_cnt++;
    if (we) begin
      wr_cnt++;
      if (!prev_re || prev_addr != addr || prev_meta != meta) seq_bad++;
    end
    prev_re = re; prev_addr = addr; prev_meta = meta;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 512; i++) begin
      mem_d[i] = 8'(i * 37 + seed * 11 + 5); exp_d[i] = mem_d[i];
    end
    for (int i = 0; i < 8; i++) begin
      mem_m[i] = 8'(i * 53 + seed); exp_m[i] = mem_m[i];
    end
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 12; i++) locs[s][i] = 13'h1FFF;
  endtask

  task automatic flip(input int loc);
    if (loc < 4096) exp_d[loc >> 3] ^= 8'(1 << (loc & 7));
    else if (loc < 4160) exp_m[(loc >> 3) - 512] ^= 8'(1 << (loc & 7));
  endtask

  task automatic check_mem(input string rq);
    int nm = 0;
    for (int i = 0; i < 512; i++) if (mem_d[i] !== exp_d[i]) nm++;
    for (int i = 0; i < 8; i++) if (mem_m[i] !== exp_m[i]) nm++;
    check(nm == 0, rq, nm, 0);
  endtask

  task automatic pulse_start(input logic [2:0] ls, input logic [2:0] st);
    @(negedge clk);
    start = 1'b1; last_sect = ls; strength = st;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk); n++;
    end
    check(done, {rq, " done pulse seen"}, done, 1);
    @(negedge clk);
    check(!done, "R10 done lasts one cycle", done, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    check(!fail && max_cnt == 0, "R1 results clear", {fail, max_cnt}, 0);
    check(!re && !we, "R1 no buffer access", {re, we}, 0);
  endtask

  task automatic t_data();
    int r0, w0;
    fill_mem(1);
    cnt_word = 32'hFFFF_FFF4; dec_done = 8'h01;
    locs[0][0] = 13'd0; locs[0][1] = 13'd4095; locs[0][2] = 13'd1234; locs[0][3] = 13'd7;
    for (int i = 0; i < 4; i++) flip(int'(locs[0][i]));
    r0 = rd_cnt; w0 = wr_cnt;
    pulse_start(3'd0, 3'd0);
    wait_done("R6");
    check_mem("R6 payload flips");
    check(max_cnt == 4 && !fail, "R4 count at limit corrected", max_cnt, 4);
    check(rd_cnt - r0 == 4 && wr_cnt - w0 == 4, "R9 one read and write per location",
          rd_cnt - r0, 4);
  endtask

  task automatic t_meta();
    int r0;
    fill_mem(2);
    cnt_word = 32'h0000_0004; dec_done = 8'h01;
    locs[0][0] = 13'd4096; locs[0][1] = 13'd4159; locs[0][2] = 13'd4160; locs[0][3] = 13'd8191;
    for (int i = 0; i < 4; i++) flip(int'(locs[0][i]));
    r0 = rd_cnt;
    pulse_start(3'd0, 3'd0);
    wait_done("R7");
    check_mem("R7 metadata flips");
    check(rd_cnt - r0 == 2, "R8 parity locations untouched", rd_cnt - r0, 2);
    check(max_cnt == 4, "R8 parity locations counted", max_cnt, 4);
  endtask

  task automatic t_over();
    int r0;
    fill_mem(3);
    cnt_word = 32'h0000_0005; dec_done = 8'h01;
    for (int i = 0; i < 5; i++) locs[0][i] = 13'(i * 8 + 1);
    r0 = rd_cnt;
    pulse_start(3'd0, 3'd0);
    wait_done("R4");
    check(fail && max_cnt == 0, "R4 above limit fails", {fail, max_cnt}, 16);
    check(rd_cnt == r0, "R4 no flips when uncorrectable", rd_cnt - r0, 0);
    check_mem("R4 buffer unchanged");
  endtask

  task automatic t_zero();
    int r0;
    fill_mem(4);
    cnt_word = 32'h0000_0000; dec_done = 8'h01;
    locs[0][0] = 13'd9;
    r0 = rd_cnt;
    pulse_start(3'd0, 3'd0);
    wait_done("R3");
    check(rd_cnt == r0, "R3 zero count no access", rd_cnt - r0, 0);
    check(!fail && max_cnt == 0, "R10 results cleared by start", {fail, max_cnt}, 0);
    check_mem("R3 buffer unchanged");
  endtask

  task automatic t_multi();
    int r0;
    fill_mem(5);
    cnt_word = 32'h3333_5F02; dec_done = 8'h01;
    locs[0][0] = 13'd10; locs[0][1] = 13'd4100;
    for (int i = 0; i < 12; i++) locs[2][i] = 13'(50 + i);
    locs[3][0] = 13'd20; locs[3][1] = 13'd21; locs[3][2] = 13'd22;
    locs[3][3] = 13'd23; locs[3][4] = 13'd4097;
    for (int i = 0; i < 3; i++) locs[4][i] = 13'(300 + i);
    flip(10); flip(4100);
    for (int i = 0; i < 5; i++) flip(int'(locs[3][i]));
    r0 = rd_cnt;
    pulse_start(3'd3, 3'd1);
    repeat (12) @(negedge clk);
    check(rd_cnt - r0 == 2, "R2 sector 0 handled first", rd_cnt - r0, 2);
    check(sect == 3'd1 && busy, "R2 waiting on sector 1 flag", sect, 1);
    repeat (30) @(negedge clk);
    check(rd_cnt - r0 == 2, "R2 no access before flag", rd_cnt - r0, 2);
    dec_done = 8'hFF;
    wait_done("R2");
    check_mem("R2 sectors 0 and 3 applied only");
    check(max_cnt == 5, "R10 max over correctable sectors", max_cnt, 5);
    check(fail, "R4 all-ones count fails", fail, 1);
  endtask

  task automatic t_cancel();
    int r0, w0;
    fill_mem(6);
    cnt_word = 32'h0000_0002; dec_done = 8'h01;
    locs[0][0] = 13'd100; locs[0][1] = 13'd100;
    r0 = rd_cnt; w0 = wr_cnt;
    pulse_start(3'd0, 3'd0);
    wait_done("R9");
    check_mem("R9 repeated location cancels");
    check(wr_cnt - w0 == 2 && rd_cnt - r0 == 2, "R9 two accesses", wr_cnt - w0, 2);
    check(max_cnt == 2, "R10 max for cancel case", max_cnt, 2);
  endtask

  task automatic t_twelve();
    fill_mem(7);
    cnt_word = 32'h0000_000C; dec_done = 8'h01;
    for (int i = 0; i < 12; i++) begin
      locs[0][i] = 13'(i * 341 + 3); flip(i * 341 + 3);
    end
    pulse_start(3'd0, 3'd7);
    wait_done("R5");
    check_mem("R5 all twelve slots unpacked");
    check(max_cnt == 12 && !fail, "R4 code 7 allows twelve", max_cnt, 12);
  endtask

  task automatic t_code2();
    fill_mem(8);
    cnt_word = 32'h0000_0009; dec_done = 8'h01;
    for (int i = 0; i < 9; i++) locs[0][i] = 13'(i * 16);
    pulse_start(3'd0, 3'd2);
    wait_done("R4");
    check(fail, "R4 nine above code 2 limit", fail, 1);
    cnt_word = 32'h0000_0008;
    for (int i = 0; i < 8; i++) flip(i * 16);
    pulse_start(3'd0, 3'd2);
    wait_done("R4");
    check(!fail && max_cnt == 8, "R4 eight within code 2 limit", max_cnt, 8);
    check_mem("R6 code 2 flips");
  endtask

  initial begin
    fill_mem(0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_data();
    t_meta();
    t_over();
    t_zero();
    t_multi();
    t_cancel();
    t_twelve();
    t_code2();
    check(seq_bad == 0, "R9 write follows read same address", seq_bad, 0);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule